// File: doc/BRIEF.md
# Polyphase Symmetric Half-Rate FIR Decimator

This block takes a stream of signed fixed-point samples, qualified by a valid strobe, and returns one filtered sample for every two it accepts. It sits behind an integrator-comb decimator. One instance, built in its droop-correcting configuration, lifts the upper passband to cancel the comb stage's roll-off. A second instance, built in its half-band configuration, forms the last halving of the rate. With the comb stage decimating by 16 and the two halving stages, the overall ratio is 64.

Rate reduction takes place before any arithmetic. Incoming samples are steered alternately into an even-index history and an odd-index history. The multiply-accumulate runs only when the second sample of a pair arrives. Because the coefficients are mirror-symmetric, the two history taps that share a coefficient are summed first, so each distinct coefficient needs a single multiplier. In the half-band variant the structurally zero coefficients produce no hardware at all, and the centre tap is a one-bit arithmetic shift of an odd-branch sample. The full-precision sum is rounded and then clipped to the output width.

A two-state controller sets the phase. In state `PH_EVEN`, an accepted sample loads the even history and the controller moves to `PH_ODD` (transition *take-even*). In state `PH_ODD`, an accepted sample triggers the output computation, loads the odd history and returns the controller to `PH_EVEN` (transition *take-odd-and-emit*). A cycle with the strobe low is *hold* and keeps the current state.

Top module: `poly_dec2_fir`

## Requirements
- R1: Reset clears the phase to even, clears both branch histories to zero, drives out_valid low and drives out_data to zero.
- R2: The phase advances only in a cycle where in_valid is high. A cycle with in_valid low leaves the phase and both histories untouched, so gaps in the input stream do not change any later output.
- R3: Accepted samples are indexed from 0 after reset. out_valid is high for exactly one cycle, in the cycle that follows the acceptance of each odd-index sample, and it is low at all other times.
- R4: With HALF_BAND=0 there are 16 taps. Output m equals the saturated, rounded value of the sum over k=0..15 of h[k]·x[2m+1−k] divided by 2^15, with samples before reset taken as zero. h[0..7] = −120, 310, −600, 980, −1500, 2300, −3900, 18914, and h[15−k] = h[k]. Samples and output are two's-complement with 15 fraction bits.
- R5: An impulse on an even-index sample produces outputs weighted by the odd-index coefficients. An impulse on an odd-index sample produces outputs weighted by the even-index coefficients.
- R6: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15, so exact halves go toward positive infinity (+1.5 becomes 2, −1.5 becomes −1, +0.5 becomes 1, −0.5 becomes 0).
- R7: A rounded value outside [−2^(OUT_W−1), 2^(OUT_W−1)−1] is clipped to the nearer bound.
- R8: With HALF_BAND=1 there are 33 taps. h[16] = 16384 (one half). Every other even k has h[k] = 0. h[1], h[3], …, h[15] = 20, −60, 140, −290, 540, −980, 1900, 6922, and h[32−k] = h[k]. The output formula and rounding are those of R4 and R6 with 33 taps.
- R9: out_data keeps its value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse per decimated output |
| out_data | output | OUT_W | Signed filtered, rounded, saturated output |

## Verification
The bound checker watches the phase controller and the output timing on every cycle. It checks that the phase flips on each accepted sample and holds on idle cycles, that every output pulse follows an accepted odd-phase sample, that pulses never come back to back, and that the output value is frozen between pulses. The numerical behaviour can only be shown by the bench scenarios. These include the even- and odd-index impulses that expose the two polyphase branches, tie-rounding at the half-band centre tap, clipping in both directions, gapped random streams compared against a full-rate reference filter, and a reset issued mid-pair.

// File: rtl/dec2_pkg.sv
package dec2_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } dec_phase_e;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;
    localparam int CS_TAPS   = 16;
    localparam int HB_TAPS   = 33;

    // first half of the droop-correcting response, index 0..7
    localparam int CS_HALF [8] = '{-120, 310, -600, 980, -1500, 2300, -3900, 18914};
    // odd-index half-band coefficients 1,3,...,15
    localparam int HB_ODD  [8] = '{20, -60, 140, -290, 540, -980, 1900, 6922};

    function automatic int coef_of(input int hb, input int k);
        int m;
        if (hb != 0) begin
            if (k == (HB_TAPS - 1) / 2) return 1 <<< (COEF_FRAC - 1);
            if ((k % 2) == 0)           return 0;
            m = (k < 16) ? k : (HB_TAPS - 1 - k);
            return HB_ODD[(m - 1) / 2];
        end
        m = (k < CS_TAPS / 2) ? k : (CS_TAPS - 1 - k);
        return CS_HALF[m];
    endfunction

endpackage

// File: rtl/dec2_phase_ctrl.sv
module dec2_phase_ctrl
    import dec2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output dec_phase_e phase,
    output logic       load_even,
    output logic       load_odd
);

    dec_phase_e phase_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_EVEN;
        else        phase <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase;
        load_even = 1'b0;
        load_odd  = 1'b0;
        unique case (phase)
            PH_EVEN: begin
                if (in_valid) begin
                    load_even = 1'b1;
                    phase_nxt = PH_ODD;
                end
            end
            PH_ODD: begin
                if (in_valid) begin
                    load_odd  = 1'b1;
                    phase_nxt = PH_EVEN;
                end
            end
        endcase
    end

endmodule

// File: rtl/dec2_branch_line.sv
module dec2_branch_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [DATA_W-1:0]             din,
    output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

    always_ff @(posedge clk) begin
        if (!rst_n)        taps <= '0;
        else if (shift_en) taps <= {taps[DEPTH-2:0], din};
    end

endmodule

// File: rtl/dec2_preadd_mac.sv
module dec2_preadd_mac
    import dec2_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HALF_BAND = 0,
    parameter int NTAPS     = 16,
    parameter int E_DEPTH   = 8,
    parameter int O_DEPTH   = 7,
    parameter int ACC_W     = 37
) (
    input  logic [DATA_W-1:0]              cur_odd,
    input  logic [E_DEPTH-1:0][DATA_W-1:0] ev,
    input  logic [O_DEPTH-1:0][DATA_W-1:0] od,
    output logic signed [ACC_W-1:0]        acc
);

    localparam int NPAIR  = (HALF_BAND != 0) ? (NTAPS - 1) / 4 : NTAPS / 2;
    localparam int PS_W   = DATA_W + 1;
    localparam int PROD_W = PS_W + COEF_W;

    logic signed [PROD_W-1:0] prod [NPAIR];
    logic signed [ACC_W-1:0]  centre;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic signed [DATA_W-1:0] ta, tb;
        logic signed [PS_W-1:0]   psum;
        if (HALF_BAND != 0) begin : g_hb
            localparam int KA = 2 * p + 1;
            localparam logic signed [PROD_W-1:0] CK = PROD_W'(coef_of(1, KA));
            assign ta = ev[p];
            assign tb = ev[E_DEPTH-1-p];
            assign prod[p] = PROD_W'(psum) * CK;
        end else begin : g_cs
            localparam int KA = p;
            localparam int KB = NTAPS - 1 - p;
            localparam logic signed [PROD_W-1:0] CK = PROD_W'(coef_of(0, KA));
            if (KA == 0) begin : g_a_now
                assign ta = cur_odd;
            end else if ((KA % 2) == 0) begin : g_a_odd
                assign ta = od[KA/2-1];
            end else begin : g_a_even
                assign ta = ev[(KA-1)/2];
            end
            if ((KB % 2) == 1) begin : g_b_even
                assign tb = ev[(KB-1)/2];
            end else begin : g_b_odd
                assign tb = od[KB/2-1];
            end
            assign prod[p] = PROD_W'(psum) * CK;
        end
        assign psum = {ta[DATA_W-1], ta} + {tb[DATA_W-1], tb};
    end

    if (HALF_BAND != 0) begin : g_centre
        logic signed [DATA_W-1:0] c_tap;
        assign c_tap  = od[O_DEPTH-1];
        assign centre = ACC_W'(c_tap) <<< (COEF_FRAC - 1);
    end else begin : g_no_centre
        assign centre = '0;
    end

    always_comb begin
        acc = centre;
        for (int p = 0; p < NPAIR; p++) acc = acc + ACC_W'(prod[p]);
    end

endmodule

// File: rtl/dec2_round_sat.sv
module dec2_round_sat
    import dec2_pkg::*;
#(
    parameter int ACC_W = 37,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        y
);

    localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO   = -SAT_HI - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (COEF_FRAC - 1);

    logic signed [ACC_W-1:0] biased, scaled;

    always_comb begin
        biased = acc + HALF_LSB;
        scaled = biased >>> COEF_FRAC;
        if (scaled > SAT_HI)      y = SAT_HI[OUT_W-1:0];
        else if (scaled < SAT_LO) y = SAT_LO[OUT_W-1:0];
        else                      y = scaled[OUT_W-1:0];
    end

endmodule

// File: rtl/poly_dec2_fir.sv
module poly_dec2_fir
    import dec2_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int OUT_W     = 16,
    parameter int HALF_BAND = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    localparam int NTAPS   = (HALF_BAND != 0) ? HB_TAPS : CS_TAPS;
    localparam int E_DEPTH = NTAPS / 2;
    localparam int O_DEPTH = (HALF_BAND != 0) ? (NTAPS - 1) / 4 : (NTAPS - 1) / 2;
    localparam int ACC_W   = DATA_W + COEF_W + 5;

    dec_phase_e phase;
    logic       phase_odd;
    logic       load_even, load_odd;

    logic [E_DEPTH-1:0][DATA_W-1:0] ev_taps;
    logic [O_DEPTH-1:0][DATA_W-1:0] od_taps;
    logic signed [ACC_W-1:0]        acc;
    logic [OUT_W-1:0]               y_next;

    assign phase_odd = (phase == PH_ODD);

    dec2_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .phase     (phase),
        .load_even (load_even),
        .load_odd  (load_odd)
    );

    dec2_branch_line #(.DATA_W(DATA_W), .DEPTH(E_DEPTH)) u_even (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (load_even),
        .din      (in_data),
        .taps     (ev_taps)
    );

    dec2_branch_line #(.DATA_W(DATA_W), .DEPTH(O_DEPTH)) u_odd (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (load_odd),
        .din      (in_data),
        .taps     (od_taps)
    );

    dec2_preadd_mac #(
        .DATA_W    (DATA_W),
        .HALF_BAND (HALF_BAND),
        .NTAPS     (NTAPS),
        .E_DEPTH   (E_DEPTH),
        .O_DEPTH   (O_DEPTH),
        .ACC_W     (ACC_W)
    ) u_mac (
        .cur_odd (in_data),
        .ev      (ev_taps),
        .od      (od_taps),
        .acc     (acc)
    );

    dec2_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rs (
        .acc (acc),
        .y   (y_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= load_odd;
            if (load_odd) out_data <= y_next;
        end
    end

endmodule

// File: rtl/dec2_fir_checker.sv
module dec2_fir_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             phase_odd,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (phase_odd != $past(phase_odd)));

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase_odd));

    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && $past(phase_odd)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind poly_dec2_fir dec2_fir_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .phase_odd (phase_odd),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/poly_dec2_fir_tb.sv
`timescale 1ns/1ps
module poly_dec2_fir_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        ov_cs, ov_hb;
    logic [15:0] od_cs, od_hb;

    int n_chk = 0;
    int n_bad = 0;
    int hist[$];
    int exp_cs[$], exp_hb[$], got_cs[$], got_hb[$];

    localparam int T_CS [8] = '{-120, 310, -600, 980, -1500, 2300, -3900, 18914};
    localparam int T_HB [8] = '{20, -60, 140, -290, 540, -980, 1900, 6922};
    // stimulus: impulse on sample 0; expected = h[odd]/2 for compensation mode
    localparam int IMP_IN  [16] = '{16384, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int IMP_EXP [8]  = '{155, 490, 1150, 9457, -1950, -750, -300, -60};

    always #2 clk = ~clk;

    poly_dec2_fir #(.DATA_W(16), .OUT_W(16), .HALF_BAND(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_cs), .out_data(od_cs));

    poly_dec2_fir #(.DATA_W(16), .OUT_W(16), .HALF_BAND(1)) u_dut_hb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_hb), .out_data(od_hb));

    always @(negedge clk) begin
        if (rst_n) begin
            if (ov_cs) got_cs.push_back(int'($signed(od_cs)));
            if (ov_hb) got_hb.push_back(int'($signed(od_hb)));
        end
    end

    function automatic int tb_coef(bit hb, int k);
        int m;
        if (hb) begin
            if (k == 16) return 16384;
            if (k % 2 == 0) return 0;
            m = (k < 16) ? k : 32 - k;
            return T_HB[(m - 1) / 2];
        end
        m = (k < 8) ? k : 15 - k;
        return T_CS[m];
    endfunction

    function automatic int ref_y(bit hb, int n);
        longint acc = 0;
        longint r;
        int nt = hb ? 33 : 16;
        for (int k = 0; k < nt; k++)
            if (n - k >= 0) acc += longint'(tb_coef(hb, k)) * longint'(hist[n - k]);
        r = (acc + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(v);
        hist.push_back(v);
        if (hist.size() % 2 == 0) begin
            exp_cs.push_back(ref_y(1'b0, hist.size() - 1));
            exp_hb.push_back(ref_y(1'b1, hist.size() - 1));
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        hist.delete(); exp_cs.delete(); exp_hb.delete();
        got_cs.delete(); got_hb.delete();
        rst_n = 1'b1;
    endtask

    task automatic compare(string req);
        idle(3);
        check({req, " R3 pulse count cs"}, got_cs.size(), exp_cs.size());
        check({req, " R3 pulse count hb"}, got_hb.size(), exp_hb.size());
        for (int i = 0; i < got_cs.size() && i < exp_cs.size(); i++)
            check({req, " cs"}, got_cs[i], exp_cs[i]);
        for (int i = 0; i < got_hb.size() && i < exp_hb.size(); i++)
            check({req, " hb"}, got_hb[i], exp_hb[i]);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 out_valid after reset", int'(ov_cs), 0);
        check("R1 out_data after reset", int'(od_cs), 0);
        check("R1 hb out_valid after reset", int'(ov_hb), 0);

        // R5/R4: table walk of even-index impulse
        for (int i = 0; i < 16; i++) drive(IMP_IN[i]);
        idle(3);
        for (int i = 0; i < 8; i++)
            check("R5 even impulse table", (i < got_cs.size()) ? got_cs[i] : 99999, IMP_EXP[i]);
        compare("R4 even impulse");

        // R5: odd-index impulse exposes even coefficients
        do_reset();
        drive(0); drive(16384);
        for (int i = 0; i < 16; i++) drive(0);
        compare("R5 odd impulse");
        check("R8 hb centre tap", (got_hb.size() > 8) ? got_hb[8] : 99999, 8192);
        check("R5 cs h0 weight", (got_cs.size() > 0) ? got_cs[0] : 99999, -60);

        // R6: tie rounding on the half-band centre
        do_reset();
        drive(0); drive(1);
        for (int i = 0; i < 16; i++) drive(0);
        idle(3);
        check("R6 +0.5 rounds up", (got_hb.size() > 8) ? got_hb[8] : 99999, 1);
        do_reset();
        drive(0); drive(-3);
        for (int i = 0; i < 16; i++) drive(0);
        idle(3);
        check("R6 -1.5 rounds to -1", (got_hb.size() > 8) ? got_hb[8] : 99999, -1);
        compare("R6 rounding");
        do_reset();
        drive(0); drive(-1);
        for (int i = 0; i < 16; i++) drive(0);
        idle(3);
        check("R6 -0.5 rounds to 0", (got_hb.size() > 8) ? got_hb[8] : 99999, 0);

        // R7: clipping both ways
        do_reset();
        for (int n = 0; n < 16; n++) drive(tb_coef(1'b0, n) > 0 ? 32767 : -32767);
        idle(3);
        check("R7 positive clip", (got_cs.size() > 7) ? got_cs[7] : 99999, 32767);
        compare("R7 positive");
        do_reset();
        for (int n = 0; n < 16; n++) drive(tb_coef(1'b0, n) > 0 ? -32767 : 32767);
        idle(3);
        check("R7 negative clip", (got_cs.size() > 7) ? got_cs[7] : 99999, -32768);
        compare("R7 negative");

        // R2/R9: gapped random stream against full-rate reference
        do_reset();
        for (int i = 0; i < 240; i++) begin
            drive(int'($urandom_range(0, 40000)) - 20000);
            if ($urandom_range(0, 3) == 0) begin
                logic [15:0] held;
                idle(1);
                held = od_cs;
                repeat (int'($urandom_range(1, 3))) @(negedge clk);
                check("R9 out_data held while idle", int'(od_cs), int'(held));
                check("R3 no pulse while idle", int'(ov_cs), 0);
            end
        end
        compare("R2 gapped random");

        // R1: reset in mid-pair clears phase and history
        do_reset();
        drive(12000); drive(-9000); drive(30000);
        do_reset();
        for (int i = 0; i < 40; i++) drive(int'($urandom_range(0, 65535)) - 32768);
        compare("R1 mid-pair reset");
        // R8: full-scale random in half-band mode (compared in compare)
        do_reset();
        for (int i = 0; i < 80; i++) drive(int'($urandom_range(0, 65535)) - 32768);
        compare("R8 half-band random");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule